// File: doc/BRIEF.md
# I2C Byte-Lane Word Queue

This block joins a 32-bit host register port to a byte-serial I2C engine. On the transmit path the host writes whole 32-bit words into a small word FIFO. An unpacker then hands them to the engine one byte at a time, lowest lane first. Because the address/direction byte is placed in lane 0 of the first word, address and payload bytes travel in one continuous word stream. A transmit length, given per transfer, tells the unpacker where the stream ends. When the length ends partway through a word, that word is dropped after its low lanes have been sent.

On the receive path a packer collects bytes from the engine into 32-bit words, first byte in the lowest lane. It pushes a word into a receive FIFO when four bytes have arrived or when the transfer's last byte arrives. In the second case the unused upper lanes are zero. The host polls an empty flag and pops words. Neither path ever drops engine data: the engine is held off through its valid/ready handshakes instead. A soft reset input empties both queues and clears both lane counters.

Top module: `i2c_lane_queue`

## Requirements
- R1: Transmit bytes leave in lane order: bits 7:0 of a word first and bits 31:24 last, then the next queued word. A first word holding the address byte in lane 0 therefore sends the address before payload bytes 0 to 2.
- R2: When the transmit length runs out partway through a word, only the low (length mod 4) lanes of that word are sent. The word is then discarded, so the next transfer starts at lane 0 of the following queued word.
- R3: Received bytes are packed four per word, the first byte of each group in bits 7:0 and the fourth in bits 31:24.
- R4: The last byte of a receive transfer pushes its word at once, even if fewer than four lanes are filled. The unfilled upper lanes read as zero.
- R5: `rx_empty` is 1 while no packed word is queued, and `rx_rdata` is 0 at that time. A read of an empty queue changes no state.
- R6: `eng_tx_valid` is 0 when the transmit FIFO is empty or no transmit bytes remain. While `eng_tx_valid` is 1 and the engine does not take the byte, the byte on `eng_tx_byte` holds.
- R7: `eng_rx_ready` is 0 when the receive FIFO is full or no receive bytes remain, so no engine byte is ever lost.
- R8: `tx_full` is 1 when TX_DEPTH words are queued. A host write while full is refused and leaves the queued words unchanged.
- R9: A `soft_rst` pulse empties both FIFOs, clears both remaining-byte counts, and discards any partial receive word and any transmit lane position.
- R10: A host push and an engine-side pop of the transmit FIFO in the same cycle both take effect. The same holds for a packer push and a host pop of the receive FIFO in one cycle.
- R11: After `rst_n` is released, `tx_full`=0, `rx_empty`=1, `eng_tx_valid`=0, `eng_rx_ready`=0 and `rx_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both paths |
| tx_wr_en | input | 1 | Host pushes `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 32 | Transmit word, lane 0 sent first |
| tx_full | output | 1 | Transmit FIFO holds TX_DEPTH words |
| tx_start | input | 1 | Load the transmit byte count |
| tx_len | input | LEN_W | Transmit byte count, address byte included |
| eng_tx_valid | output | 1 | A transmit byte is offered to the engine |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_tx_byte | output | 8 | Offered transmit byte |
| rx_start | input | 1 | Load the receive byte count |
| rx_len | input | LEN_W | Receive byte count |
| eng_rx_valid | input | 1 | Engine presents a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Block can accept a received byte |
| rx_rd_en | input | 1 | Host pops the head receive word |
| rx_rdata | output | 32 | Head receive word, zero when empty |
| rx_empty | output | 1 | No packed receive word is queued |

## Verification
Each FIFO has two writers to its occupancy in one cycle. On the transmit side, the engine taking the fourth lane of a word can coincide with a host write. On the receive side, the packer completing a word can coincide with a host read. The bench lines up both coincidences on purpose: it takes lane 3 while writing a new word, and it delivers a fourth byte while popping the previous word. It then judges the result by draining the queues. The exact following word must appear, nothing extra may follow, and the empty flag must rise only after the last expected word.

// File: rtl/i2c_lane_pkg.sv
package i2c_lane_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  // byte held in a given lane of a word
  function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w,
                                           input logic [LANE_W-1:0] idx);
    return w[idx*8 +: 8];
  endfunction

  // a word is finished at the top lane or on the transfer's final byte
  function automatic logic word_done(input logic [LANE_W-1:0] lane,
                                     input logic final_byte);
    return (lane == LANE_W'(LANES-1)) || final_byte;
  endfunction
endpackage

// File: rtl/i2c_word_fifo.sv
module i2c_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tx_unpacker.sv
module i2c_tx_unpacker
  import i2c_lane_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] head,
  input  logic              head_ok,
  input  logic              take,
  output logic              valid,
  output logic [7:0]        byte_o,
  output logic              fire,
  output logic              pop
);
  logic [LEN_W-1:0]  remain;
  logic [LANE_W-1:0] lane;

  assign valid  = (remain != '0) && head_ok;
  assign byte_o = lane_byte(head, lane);
  assign fire   = valid && take;
  assign pop    = fire && word_done(lane, remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      lane   <= '0;
    end else if (flush) begin
      remain <= '0;
      lane   <= '0;
    end else if (start) begin
      remain <= len;
      lane   <= '0;
    end else if (fire) begin
      remain <= remain - 1'b1;
      lane   <= pop ? '0 : lane + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rx_packer.sv
module i2c_rx_packer
  import i2c_lane_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              room,
  output logic              ready,
  output logic              fire,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  logic [LEN_W-1:0]  remain;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;

  assign ready = (remain != '0) && room;
  assign fire  = ready && in_valid;
  assign push  = fire && word_done(lane, remain == LEN_W'(1));
  assign word  = merged;

  // lanes above the current one are still zero in acc
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = (lane == LANE_W'(g)) ? in_byte : acc[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      lane   <= '0;
      acc    <= '0;
    end else if (flush) begin
      remain <= '0;
      lane   <= '0;
      acc    <= '0;
    end else if (start) begin
      remain <= len;
      lane   <= '0;
      acc    <= '0;
    end else if (fire) begin
      remain <= remain - 1'b1;
      lane   <= push ? '0 : lane + 1'b1;
      acc    <= push ? '0 : merged;
    end
  end
endmodule

// File: rtl/i2c_lane_queue.sv
module i2c_lane_queue
  import i2c_lane_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_wr_en,
  input  logic [31:0]      tx_wdata,
  output logic             tx_full,
  input  logic             tx_start,
  input  logic [LEN_W-1:0] tx_len,
  output logic             eng_tx_valid,
  input  logic             eng_tx_ready,
  output logic [7:0]       eng_tx_byte,
  input  logic             rx_start,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             eng_rx_valid,
  input  logic [7:0]       eng_rx_byte,
  output logic             eng_rx_ready,
  input  logic             rx_rd_en,
  output logic [31:0]      rx_rdata,
  output logic             rx_empty
);
  // named internal events, used by the bound checker
  logic              tx_empty_w, tx_fire, tx_pop;
  logic [WORD_W-1:0] tx_head;
  logic              rx_full_w, rx_fire, rx_push;
  logic [WORD_W-1:0] rx_word, rx_head;

  i2c_word_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_wr_en), .din(tx_wdata), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty_w)
  );

  i2c_tx_unpacker #(.LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .start(tx_start), .len(tx_len),
    .head(tx_head), .head_ok(!tx_empty_w), .take(eng_tx_ready),
    .valid(eng_tx_valid), .byte_o(eng_tx_byte), .fire(tx_fire), .pop(tx_pop)
  );

  i2c_rx_packer #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .start(rx_start), .len(rx_len),
    .in_valid(eng_rx_valid), .in_byte(eng_rx_byte), .room(!rx_full_w),
    .ready(eng_rx_ready), .fire(rx_fire), .push(rx_push), .word(rx_word)
  );

  i2c_word_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rx_push), .din(rx_word), .pop(rx_rd_en),
    .dout(rx_head), .full(rx_full_w), .empty(rx_empty)
  );

  assign rx_rdata = rx_empty ? '0 : rx_head;
endmodule

// File: rtl/i2c_lane_queue_chk.sv
module i2c_lane_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        tx_start,
  input logic        tx_full,
  input logic        tx_empty_w,
  input logic        eng_tx_valid,
  input logic        eng_tx_ready,
  input logic [7:0]  eng_tx_byte,
  input logic        rx_full_w,
  input logic        rx_push,
  input logic        eng_rx_ready,
  input logic        rx_rd_en,
  input logic        rx_empty
);
  // R6
  tx_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_w |-> !eng_tx_valid);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready && !tx_start && !soft_rst)
      |=> (eng_tx_valid && $stable(eng_tx_byte)));

  // R7
  rx_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_w |-> !eng_rx_ready);

  // R5
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_rd_en && !rx_push && !soft_rst) |=> rx_empty);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rx_empty && !tx_full && !eng_tx_valid && !eng_rx_ready));
endmodule

bind i2c_lane_queue i2c_lane_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_start(tx_start),
  .tx_full(tx_full), .tx_empty_w(tx_empty_w),
  .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
  .eng_tx_byte(eng_tx_byte), .rx_full_w(rx_full_w), .rx_push(rx_push),
  .eng_rx_ready(eng_rx_ready), .rx_rd_en(rx_rd_en), .rx_empty(rx_empty)
);

// File: tb/tb_i2c_lane_queue.sv
module tb_i2c_lane_queue;
  localparam int TXD = 4;
  localparam int RXD = 4;
  localparam int LW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic tx_wr_en = 1'b0, tx_full, tx_start = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic [LW-1:0] tx_len = '0, rx_len = '0;
  logic eng_tx_valid, eng_tx_ready = 1'b0;
  logic [7:0] eng_tx_byte, eng_rx_byte = '0;
  logic rx_start = 1'b0, eng_rx_valid = 1'b0, eng_rx_ready;
  logic rx_rd_en = 1'b0, rx_empty;
  logic [31:0] rx_rdata;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  i2c_lane_queue #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .LEN_W(LW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic host_write(input logic [31:0] w);
    tx_wr_en = 1'b1; tx_wdata = w;
    @(negedge clk); tx_wr_en = 1'b0;
  endtask
  task automatic tx_go(input int n);
    tx_start = 1'b1; tx_len = LW'(n);
    @(negedge clk); tx_start = 1'b0;
  endtask
  task automatic rx_go(input int n);
    rx_start = 1'b1; rx_len = LW'(n);
    @(negedge clk); rx_start = 1'b0;
  endtask
  task automatic take(input logic [7:0] exp, input string req);
    chk({req, " tx valid"}, 32'(eng_tx_valid), 32'd1);
    chk({req, " tx byte"}, 32'(eng_tx_byte), 32'(exp));
    eng_tx_ready = 1'b1;
    @(negedge clk); eng_tx_ready = 1'b0;
  endtask
  task automatic give(input logic [7:0] b, input string req);
    chk({req, " rx ready"}, 32'(eng_rx_ready), 32'd1);
    eng_rx_valid = 1'b1; eng_rx_byte = b;
    @(negedge clk); eng_rx_valid = 1'b0;
  endtask
  task automatic hread(input logic [31:0] exp, input string req);
    chk({req, " rx nonempty"}, 32'(rx_empty), 32'd0);
    chk({req, " rx word"}, rx_rdata, exp);
    rx_rd_en = 1'b1;
    @(negedge clk); rx_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 tx_full", 32'(tx_full), 0);
    chk("R11 rx_empty", 32'(rx_empty), 1);
    chk("R11 tx_valid", 32'(eng_tx_valid), 0);
    chk("R11 rx_ready", 32'(eng_rx_ready), 0);
    chk("R11 rdata", rx_rdata, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b [8] = '{8'hA4, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    host_write(pk(b[0], b[1], b[2], b[3]));
    host_write(pk(b[4], b[5], b[6], b[7]));
    tx_go(8);
    for (int i = 0; i < 8; i++) take(b[i], "R1");
    chk("R6 no bytes left", 32'(eng_tx_valid), 0);
  endtask

  task automatic t_tx_partial();
    host_write(pk(8'hA0, 8'h11, 8'h22, 8'h33));
    host_write(pk(8'h55, 8'h66, 8'hAD, 8'hDE));
    host_write(pk(8'h01, 8'h02, 8'h03, 8'h04));
    tx_go(6);
    take(8'hA0, "R2"); take(8'h11, "R2"); take(8'h22, "R2"); take(8'h33, "R2");
    take(8'h55, "R2"); take(8'h66, "R2");
    chk("R2 stops at length", 32'(eng_tx_valid), 0);
    tx_go(4);
    for (int i = 1; i <= 4; i++) take(8'(i), "R2 next word lane0");
  endtask

  task automatic t_tx_stall();
    tx_go(5);
    chk("R6 empty fifo stalls", 32'(eng_tx_valid), 0);
    host_write(pk(8'h10, 8'h20, 8'h30, 8'h40));
    repeat (3) @(negedge clk);
    chk("R6 byte held", 32'(eng_tx_byte), 32'h10);
    take(8'h10, "R6"); take(8'h20, "R6"); take(8'h30, "R6"); take(8'h40, "R6");
    chk("R6 stall mid transfer", 32'(eng_tx_valid), 0);
    host_write(pk(8'h50, 8'h00, 8'h00, 8'h00));
    take(8'h50, "R6 resume");
    chk("R6 done", 32'(eng_tx_valid), 0);
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < TXD; i++) host_write({4{8'(8'h80 + i)}});
    chk("R8 full", 32'(tx_full), 1);
    host_write(32'hBADBADBA);
    tx_go(4 * TXD);
    for (int i = 0; i < TXD; i++)
      for (int l = 0; l < 4; l++) take(8'(8'h80 + i), "R8 kept words");
    chk("R8 refused word absent", 32'(eng_tx_valid), 0);
    chk("R8 not full", 32'(tx_full), 0);
  endtask

  task automatic t_rx_pack();
    logic [7:0] b [6] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6};
    rx_go(6);
    for (int i = 0; i < 6; i++) give(b[i], "R3");
    hread(pk(b[0], b[1], b[2], b[3]), "R3");
    hread(pk(b[4], b[5], 8'h00, 8'h00), "R4 zero pad");
    chk("R5 empty after", 32'(rx_empty), 1);
    chk("R7 no bytes left", 32'(eng_rx_ready), 0);
  endtask

  task automatic t_rx_empty_read();
    chk("R5 rdata zero", rx_rdata, 0);
    rx_rd_en = 1'b1; @(negedge clk); rx_rd_en = 1'b0;
    chk("R5 still empty", 32'(rx_empty), 1);
    rx_go(1);
    give(8'h5A, "R5");
    hread(32'h0000005A, "R5 after empty read");
    chk("R5 empty again", 32'(rx_empty), 1);
  endtask

  task automatic t_rx_full();
    rx_go(4 * RXD + 1);
    for (int i = 0; i < 4 * RXD; i++) give(8'(i), "R7");
    chk("R7 full stalls", 32'(eng_rx_ready), 0);
    hread(pk(8'd0, 8'd1, 8'd2, 8'd3), "R7");
    give(8'hEE, "R7 resume");
    for (int w = 1; w < RXD; w++)
      hread(pk(8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)), "R7");
    hread(32'h000000EE, "R7 last");
  endtask

  task automatic t_simul();
    host_write(pk(8'hA1, 8'hA2, 8'hA3, 8'hA4));
    tx_go(8);
    take(8'hA1, "R10"); take(8'hA2, "R10"); take(8'hA3, "R10");
    chk("R10 lane3", 32'(eng_tx_byte), 32'hA4);
    eng_tx_ready = 1'b1; tx_wr_en = 1'b1; tx_wdata = pk(8'hB1, 8'hB2, 8'hB3, 8'hB4);
    @(negedge clk); eng_tx_ready = 1'b0; tx_wr_en = 1'b0;
    take(8'hB1, "R10"); take(8'hB2, "R10"); take(8'hB3, "R10"); take(8'hB4, "R10");
    tx_go(1);
    chk("R10 tx fifo drained", 32'(eng_tx_valid), 0);
    tx_go(0);
    rx_go(8);
    for (int i = 0; i < 7; i++) give(8'(8'hD0 + i), "R10");
    chk("R10 rx ready", 32'(eng_rx_ready), 1);
    chk("R10 head word", rx_rdata, pk(8'hD0, 8'hD1, 8'hD2, 8'hD3));
    eng_rx_valid = 1'b1; eng_rx_byte = 8'hD7; rx_rd_en = 1'b1;
    @(negedge clk); eng_rx_valid = 1'b0; rx_rd_en = 1'b0;
    hread(pk(8'hD4, 8'hD5, 8'hD6, 8'hD7), "R10");
    chk("R10 rx drained", 32'(rx_empty), 1);
  endtask

  task automatic t_soft();
    host_write(32'h11111111); host_write(32'h22222222);
    tx_go(8);
    take(8'h11, "R9 pre");
    rx_go(8);
    for (int i = 0; i < 5; i++) give(8'hF0, "R9 pre");
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk("R9 rx_empty", 32'(rx_empty), 1);
    chk("R9 tx_full", 32'(tx_full), 0);
    chk("R9 tx_valid", 32'(eng_tx_valid), 0);
    chk("R9 rx_ready", 32'(eng_rx_ready), 0);
    host_write(pk(8'h61, 8'h62, 8'h63, 8'h64));
    tx_go(4);
    take(8'h61, "R9 lane0"); take(8'h62, "R9"); take(8'h63, "R9"); take(8'h64, "R9");
    chk("R9 old words gone", 32'(eng_tx_valid), 0);
    rx_go(2);
    give(8'h71, "R9"); give(8'h72, "R9");
    hread(32'h00007271, "R9 no stale lanes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_partial();
    t_tx_stall();
    t_tx_full();
    t_rx_pack();
    t_rx_empty_read();
    t_rx_full();
    t_simul();
    t_soft();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule